// File: doc/BRIEF.md
# Circular-Buffer DMA Burst Scheduler

This block moves 64-bit words from one stream queue into system memory through a write-only AXI4 master. The words land in a circular segment placed inside a global buffer window. All segment addresses are byte offsets from the window base, and the segment end is the first byte past the segment. The block keeps the write pointer for the segment. The pointer moves forward only when memory confirms a burst with an OKAY response. When the pointer reaches the segment end, it returns to the segment start in the same cycle.

When enough data is queued, the block issues 16-beat bursts. When the queue holds too little, the block waits for a programmable time, and after that it drains the queue one beat per burst. Software controls the flow in four ways:
- A limit offset that the pointer may not pass.
- An interrupt offset that sets a sticky pending flag.
- A master enable.
- Two sticky error flags. One blocks bursts whose range falls outside the window. The other blocks further bursts after a burst is answered with an error response.

Top module: `dma_burst_scheduler`

## Requirements
- R1: With at least BURST_LEN words queued, a pointer that is a multiple of BURST_LEN*8 and at least BURST_LEN*8 bytes of room before the limit, the block issues one burst with awLen = BURST_LEN-1, awSize = 3 (8 bytes), awBurst = 1 (INCR), wStrb = all ones and awAddr = bufBase + wrPtr. It does so without the partial-data wait.
- R2: When fewer words than a full burst are queued, no burst starts for WAIT_CYCLES cycles. After that wait, the queued words go out as single-beat bursts (awLen = 0) until the queue is empty.
- R3: When the pointer is not aligned to BURST_LEN*8, queued data goes out as single-beat bursts, even when BURST_LEN or more words are waiting.
- R4: segInit loads wrPtr with segStart. Each OKAY response advances wrPtr by the burst size in bytes. A pointer that reaches segEnd becomes segStart.
- R5: While wrPtr equals segLimit, no burst starts. Moving the limit lets bursts resume.
- R6: intrPending is set when a confirmed burst carries the pointer over or onto intrAddr while intrEnable is 1. It stays set until intrClear.
- R7: A burst whose last byte would lie at or beyond bufSize, or any burst while bufSize is 0, is never placed on the bus and sets addrError. No burst starts while addrError is set, and errClear removes it.
- R8: A write response other than OKAY sets respError. The pointer does not move, ackValid does not pulse, and no burst starts until errClear.
- R9: Clearing dmaEnable during a burst lets that burst complete. No new burst starts while dmaEnable is 0.
- R10: Each accepted data beat pops exactly one queue word, and the beats carry the words in queue order. wLast is high on the final beat of each burst and on no other beat.
- R11: Once awValid is raised it stays high with a stable awAddr until awReady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaEnable | input | 1 | Master enable for starting bursts |
| segInit | input | 1 | Load the write pointer with segStart |
| errClear | input | 1 | Clear both error flags |
| intrClear | input | 1 | Clear the interrupt pending flag |
| intrEnable | input | 1 | Allow the interrupt offset to set the pending flag |
| bufBase | input | ADDR_W | Absolute base address of the window |
| bufSize | input | ADDR_W | Window size in bytes; 0 forbids all bursts |
| segStart | input | ADDR_W | Segment start offset |
| segEnd | input | ADDR_W | Offset one past the segment end |
| segLimit | input | ADDR_W | Offset the pointer may not pass |
| intrAddr | input | ADDR_W | Offset that raises the interrupt |
| fifoLevel | input | LVL_W | Number of words in the queue |
| fifoData | input | DATA_W | Word at the queue head |
| fifoRead | output | 1 | Pops the queue head |
| ackValid | output | 1 | Pulses when a burst is confirmed |
| wrPtr | output | ADDR_W | Current write pointer offset |
| addrError | output | 1 | Sticky window-range error |
| respError | output | 1 | Sticky write-response error |
| intrPending | output | 1 | Sticky interrupt flag |
| awValid | output | 1 | AXI write address valid |
| awReady | input | 1 | AXI write address ready |
| awAddr | output | ADDR_W | AXI write address |
| awLen | output | 8 | AXI burst length minus one |
| awSize | output | 3 | AXI beat size code |
| awBurst | output | 2 | AXI burst type |
| wValid | output | 1 | AXI write data valid |
| wReady | input | 1 | AXI write data ready |
| wData | output | DATA_W | AXI write data |
| wStrb | output | DATA_W/8 | AXI byte strobes |
| wLast | output | 1 | AXI last beat |
| bValid | input | 1 | AXI write response valid |
| bReady | output | 1 | AXI write response ready |
| bResp | input | 2 | AXI write response code |

## Verification
Some rules can be checked on every cycle, and the assertions cover them:
- A held address request keeps its address.
- A burst length is only 1 or BURST_LEN beats.
- A full burst starts only from an aligned pointer.
- The queue is never popped when empty.
- A pointer never changes without either an OKAY response or segInit, and never leaves the segment.
- No burst rises while an error flag is set or while the pointer sat on the limit.

Other behaviour depends on timing, and only the bench scenarios can show it:
- The length of the partial-data wait.
- The switch to draining one beat at a time.
- Wrap-around onto the limit.
- The interrupt crossing.
- Completion of a burst after the enable is dropped.

The bench computes the expected pointer, counts and addresses for each of these by arithmetic.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_ADDR, ST_DATA, ST_RESP} schedState_t;

  typedef struct packed {
    logic init;    // load pointer with segment start
    logic start;   // latch burst kind, reset beat count
    logic full;    // burst kind being started is full-length
    logic beat;    // one data beat accepted
    logic commit;  // OKAY response: advance pointer
  } dpStrobe_t;
endpackage

// File: rtl/dma_sched_datapath.sv
module dma_sched_datapath
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 13,
  parameter int BURST_LEN = 16,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] bufBase,
  input  logic [ADDR_W-1:0] bufSize,
  input  logic [ADDR_W-1:0] segStart,
  input  logic [ADDR_W-1:0] segEnd,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic [ADDR_W-1:0] intrAddr,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] awAddr,
  output logic              isFull,
  output logic              lastBeat,
  output logic              haveData,
  output logic              atLimit,
  output logic              fullOk,
  output logic              fullFits,
  output logic              singleFits,
  output logic              intrHit
);
  localparam int BURST_BYTES = BURST_LEN * BEAT_BYTES;
  localparam int ALIGN_BITS  = $clog2(BURST_BYTES);
  localparam int BEAT_W      = $clog2(BURST_LEN) + 1;
  localparam logic [ADDR_W:0] FULL_STEP = (ADDR_W+1)'(BURST_BYTES);
  localparam logic [ADDR_W:0] ONE_STEP  = (ADDR_W+1)'(BEAT_BYTES);

  logic [ADDR_W-1:0] ptr, nextPtr;
  logic [ADDR_W:0]   stepBytes, sumPtr, limDist, sizeExt;
  logic [BEAT_W-1:0] beatCnt;
  logic              fullReg;

  assign stepBytes = fullReg ? FULL_STEP : ONE_STEP;
  assign sumPtr    = {1'b0, ptr} + stepBytes;
  assign nextPtr   = (sumPtr >= {1'b0, segEnd}) ? segStart : sumPtr[ADDR_W-1:0];
  assign sizeExt   = {1'b0, bufSize};

  always_comb begin
    if (segLimit >= ptr) limDist = {1'b0, segLimit} - {1'b0, ptr};
    else limDist = ({1'b0, segEnd} - {1'b0, ptr}) + ({1'b0, segLimit} - {1'b0, segStart});
  end

  assign haveData   = fifoLevel != '0;
  assign atLimit    = ptr == segLimit;
  assign fullOk     = (32'(fifoLevel) >= BURST_LEN) && (ptr[ALIGN_BITS-1:0] == '0)
                      && (limDist >= FULL_STEP);
  assign fullFits   = (bufSize != '0) && (({1'b0, ptr} + FULL_STEP) <= sizeExt);
  assign singleFits = (bufSize != '0) && (({1'b0, ptr} + ONE_STEP) <= sizeExt);
  assign intrHit    = ((intrAddr > ptr) && ({1'b0, intrAddr} <= sumPtr)) || (intrAddr == nextPtr);

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (strb.init) ptr <= segStart;
    else if (strb.commit) ptr <= nextPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      fullReg <= 1'b0;
    end else if (strb.start) begin
      beatCnt <= '0;
      fullReg <= strb.full;
    end else if (strb.beat) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign lastBeat = fullReg ? (beatCnt == BEAT_W'(BURST_LEN-1)) : 1'b1;
  assign isFull   = fullReg;
  assign wrPtr    = ptr;
  assign awAddr   = bufBase + ptr;
endmodule

// File: rtl/dma_sched_ctrl.sv
module dma_sched_ctrl
  import dma_sched_pkg::*;
#(
  parameter int WAIT_CYCLES = 250
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dmaEnable,
  input  logic      segInit,
  input  logic      errClear,
  input  logic      intrClear,
  input  logic      intrEnable,
  input  logic      haveData,
  input  logic      atLimit,
  input  logic      fullOk,
  input  logic      fullFits,
  input  logic      singleFits,
  input  logic      lastBeat,
  input  logic      intrHit,
  input  logic      awReady,
  input  logic      wReady,
  input  logic      bValid,
  input  logic [1:0] bResp,
  output dpStrobe_t strb,
  output logic      awValid,
  output logic      wValid,
  output logic      bReady,
  output logic      ackValid,
  output logic      addrError,
  output logic      respError,
  output logic      intrPending
);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES - 1);

  schedState_t state, nextState;
  logic [WAIT_W-1:0] waitCnt;
  logic drainMode, canGo, tryFull, trySingle, fromTimeout, setAddrErr;

  assign canGo = dmaEnable && !addrError && !respError && !atLimit && haveData;

  always_comb begin
    strb        = '0;
    nextState   = state;
    tryFull     = 1'b0;
    trySingle   = 1'b0;
    fromTimeout = 1'b0;
    setAddrErr  = 1'b0;
    case (state)
      ST_IDLE: if (canGo) begin
        if (fullOk) tryFull = 1'b1;
        else if (drainMode) trySingle = 1'b1;
        else nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (!canGo) nextState = ST_IDLE;
        else if (fullOk) tryFull = 1'b1;
        else if (waitCnt == WAIT_LAST) begin
          trySingle   = 1'b1;
          fromTimeout = 1'b1;
        end
      end
      ST_ADDR: if (awReady) nextState = ST_DATA;
      ST_DATA: begin
        strb.beat = wReady;
        if (wReady && lastBeat) nextState = ST_RESP;
      end
      ST_RESP: if (bValid) begin
        nextState   = ST_IDLE;
        strb.commit = (bResp == 2'b00);
      end
      default: nextState = ST_IDLE;
    endcase
    if (tryFull || trySingle) begin
      if (tryFull ? fullFits : singleFits) begin
        strb.start = 1'b1;
        strb.full  = tryFull;
        nextState  = ST_ADDR;
      end else begin
        setAddrErr = 1'b1;
        nextState  = ST_IDLE;
      end
    end
    strb.init = segInit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      waitCnt     <= '0;
      drainMode   <= 1'b0;
      addrError   <= 1'b0;
      respError   <= 1'b0;
      intrPending <= 1'b0;
    end else begin
      state   <= nextState;
      waitCnt <= (state == ST_WAIT && nextState == ST_WAIT) ? waitCnt + 1'b1 : '0;
      if (tryFull) drainMode <= 1'b0;
      else if (fromTimeout) drainMode <= 1'b1;
      else if (state == ST_IDLE && !haveData) drainMode <= 1'b0;
      if (setAddrErr) addrError <= 1'b1;
      else if (errClear) addrError <= 1'b0;
      if (state == ST_RESP && bValid && bResp != 2'b00) respError <= 1'b1;
      else if (errClear) respError <= 1'b0;
      if (strb.commit && intrHit && intrEnable) intrPending <= 1'b1;
      else if (intrClear) intrPending <= 1'b0;
    end
  end

  assign awValid  = state == ST_ADDR;
  assign wValid   = state == ST_DATA;
  assign bReady   = state == ST_RESP;
  assign ackValid = strb.commit;
endmodule

// File: rtl/dma_burst_scheduler.sv
module dma_burst_scheduler
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LVL_W       = 13,
  parameter int DATA_W      = 64,
  parameter int BURST_LEN   = 16,
  parameter int WAIT_CYCLES = 250
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dmaEnable,
  input  logic                segInit,
  input  logic                errClear,
  input  logic                intrClear,
  input  logic                intrEnable,
  input  logic [ADDR_W-1:0]   bufBase,
  input  logic [ADDR_W-1:0]   bufSize,
  input  logic [ADDR_W-1:0]   segStart,
  input  logic [ADDR_W-1:0]   segEnd,
  input  logic [ADDR_W-1:0]   segLimit,
  input  logic [ADDR_W-1:0]   intrAddr,
  input  logic [LVL_W-1:0]    fifoLevel,
  input  logic [DATA_W-1:0]   fifoData,
  output logic                fifoRead,
  output logic                ackValid,
  output logic [ADDR_W-1:0]   wrPtr,
  output logic                addrError,
  output logic                respError,
  output logic                intrPending,
  output logic                awValid,
  input  logic                awReady,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic [1:0]          awBurst,
  output logic                wValid,
  input  logic                wReady,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic                wLast,
  input  logic                bValid,
  output logic                bReady,
  input  logic [1:0]          bResp
);
  localparam int BEAT_BYTES = DATA_W / 8;

  dpStrobe_t strb;
  logic isFull, lastBeat, haveData, atLimit, fullOk, fullFits, singleFits, intrHit;

  dma_sched_datapath #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .BURST_LEN(BURST_LEN), .BEAT_BYTES(BEAT_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .bufBase(bufBase), .bufSize(bufSize), .segStart(segStart), .segEnd(segEnd),
    .segLimit(segLimit), .intrAddr(intrAddr), .fifoLevel(fifoLevel),
    .wrPtr(wrPtr), .awAddr(awAddr), .isFull(isFull), .lastBeat(lastBeat),
    .haveData(haveData), .atLimit(atLimit), .fullOk(fullOk), .fullFits(fullFits),
    .singleFits(singleFits), .intrHit(intrHit)
  );

  dma_sched_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .dmaEnable(dmaEnable), .segInit(segInit),
    .errClear(errClear), .intrClear(intrClear), .intrEnable(intrEnable),
    .haveData(haveData), .atLimit(atLimit), .fullOk(fullOk), .fullFits(fullFits),
    .singleFits(singleFits), .lastBeat(lastBeat), .intrHit(intrHit),
    .awReady(awReady), .wReady(wReady), .bValid(bValid), .bResp(bResp),
    .strb(strb), .awValid(awValid), .wValid(wValid), .bReady(bReady),
    .ackValid(ackValid), .addrError(addrError), .respError(respError),
    .intrPending(intrPending)
  );

  assign awLen    = isFull ? 8'(BURST_LEN - 1) : 8'd0;
  assign awSize   = 3'($clog2(BEAT_BYTES));
  assign awBurst  = 2'b01;
  assign wData    = fifoData;
  assign wStrb    = '1;
  assign wLast    = wValid && lastBeat;
  assign fifoRead = wValid && wReady;
endmodule

// File: rtl/dma_sched_checker.sv
module dma_sched_checker #(
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 13,
  parameter int BURST_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              awValid,
  input logic              awReady,
  input logic [ADDR_W-1:0] awAddr,
  input logic [7:0]        awLen,
  input logic              fifoRead,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] segStart,
  input logic [ADDR_W-1:0] segEnd,
  input logic [ADDR_W-1:0] segLimit,
  input logic              segInit,
  input logic              bValid,
  input logic              bReady,
  input logic [1:0]        bResp,
  input logic              addrError,
  input logic              respError
);
  localparam int ALIGN_BITS = $clog2(BURST_LEN * 8);

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr)); // R11
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (awLen == 8'd0 || awLen == 8'(BURST_LEN - 1))); // R1
  AST_FULL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    awValid && awLen != 8'd0 |-> wrPtr[ALIGN_BITS-1:0] == '0); // R3
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> fifoLevel != '0); // R10
  AST_PTR_IN_SEG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrPtr) && !$past(segInit) |-> wrPtr >= segStart && wrPtr < segEnd); // R4
  AST_PTR_ONLY_OK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrPtr) |-> $past(segInit) || ($past(bValid && bReady) && $past(bResp) == 2'b00)); // R8
  AST_NO_AW_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awValid) |-> !addrError && !respError); // R7
  AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awValid) |-> $past(wrPtr != segLimit)); // R5
endmodule

bind dma_burst_scheduler dma_sched_checker #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .BURST_LEN(BURST_LEN)
) u_chk (.*);

// File: tb/dma_burst_scheduler_bench.sv
module dma_burst_scheduler_bench;
  localparam int AW = 16, LW = 8, BL = 16, WC = 8;

  logic clk = 0, rstN = 0;
  logic dmaEnable = 0, segInit = 0, errClear = 0, intrClear = 0, intrEnable = 0;
  logic [AW-1:0] bufBase = 16'h4000, bufSize = 16'h1000, segStart = 16'h0100;
  logic [AW-1:0] segEnd = 16'h0300, segLimit = 16'h02F8, intrAddr = 16'h0000;
  logic [LW-1:0] fifoLevel = 0, pushAdd = 0;
  logic [63:0] fifoData = 0, expWord = 0;
  logic fifoRead, ackValid, addrError, respError, intrPending;
  logic [AW-1:0] wrPtr, awAddr;
  logic awValid, wValid, wLast, bReady, bValidR = 0;
  logic [7:0] awLen;
  logic [2:0] awSize;
  logic [1:0] awBurst, slaveResp = 0;
  logic [63:0] wData;
  logic [7:0] wStrb;
  logic throttle = 0;

  int total = 0, bad = 0, awCount = 0, fullCount = 0, singleCount = 0, ackCount = 0;
  int dataBad = 0, lastBad = 0, fmtBad = 0, beatIdx = 0;
  logic [7:0] lastLen = 0;
  logic [AW-1:0] lastAddr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_burst_scheduler #(.ADDR_W(AW), .LVL_W(LW), .DATA_W(64), .BURST_LEN(BL), .WAIT_CYCLES(WC))
  u_dma_burst_scheduler (
    .clk(clk), .rstN(rstN), .dmaEnable(dmaEnable), .segInit(segInit), .errClear(errClear),
    .intrClear(intrClear), .intrEnable(intrEnable), .bufBase(bufBase), .bufSize(bufSize),
    .segStart(segStart), .segEnd(segEnd), .segLimit(segLimit), .intrAddr(intrAddr),
    .fifoLevel(fifoLevel), .fifoData(fifoData), .fifoRead(fifoRead), .ackValid(ackValid),
    .wrPtr(wrPtr), .addrError(addrError), .respError(respError), .intrPending(intrPending),
    .awValid(awValid), .awReady(1'b1), .awAddr(awAddr), .awLen(awLen), .awSize(awSize),
    .awBurst(awBurst), .wValid(wValid), .wReady(!throttle), .wData(wData), .wStrb(wStrb),
    .wLast(wLast), .bValid(bValidR), .bReady(bReady), .bResp(slaveResp));

  // queue model and memory-side responder
  always @(posedge clk) begin
    fifoLevel <= fifoLevel + pushAdd - (fifoRead ? 8'd1 : 8'd0);
    if (fifoRead) fifoData <= fifoData + 1;
    if (ackValid) ackCount <= ackCount + 1;
    if (awValid) begin
      awCount <= awCount + 1;
      lastLen <= awLen;
      lastAddr <= awAddr;
      beatIdx <= 0;
      if (awLen == 0) singleCount <= singleCount + 1; else fullCount <= fullCount + 1;
      if (awSize != 3'd3 || awBurst != 2'b01) fmtBad <= fmtBad + 1;
    end
    if (wValid && !throttle) begin
      if (wData != expWord) dataBad <= dataBad + 1;
      if (wStrb != 8'hFF) fmtBad <= fmtBad + 1;
      if (wLast != (beatIdx == int'(lastLen))) lastBad <= lastBad + 1;
      expWord <= expWord + 1;
      beatIdx <= beatIdx + 1;
    end
    if (wValid && !throttle && wLast) bValidR <= 1'b1;
    else if (bValidR && bReady) bValidR <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int n);
    @(negedge clk) pushAdd = 8'(n);
    @(negedge clk) pushAdd = 0;
  endtask

  task automatic pulseInit();
    @(negedge clk) segInit = 1;
    @(negedge clk) segInit = 0;
  endtask

  task automatic pulseErrClear();
    @(negedge clk) errClear = 1;
    @(negedge clk) errClear = 0;
  endtask

  int fc0, sc0, ac0, ak0;

  initial begin
    cyc(3);
    chk(awValid == 0 && wValid == 0 && bReady == 0, "R11 reset bus idle", awValid, 0);
    chk(wrPtr == 0 && !addrError && !respError && !intrPending, "R4 reset state", wrPtr, 0);
    @(negedge clk) rstN = 1;
    pulseInit();
    chk(wrPtr == 16'h0100, "R4 init pointer", wrPtr, 16'h0100);

    // full bursts, no wait
    dmaEnable = 1;
    push(32);
    cyc(3);
    chk(awCount == 1, "R1 full burst starts without wait", awCount, 1);
    cyc(60);
    chk(fullCount == 2 && singleCount == 0, "R1 two full bursts", fullCount, 2);
    chk(lastLen == 8'd15 && lastAddr == 16'h4180, "R1 length and address", lastAddr, 16'h4180);
    chk(wrPtr == 16'h0200 && ackCount == 2, "R4 pointer after 32 words", wrPtr, 16'h0200);

    // partial data: wait then single beats
    push(3);
    cyc(4);
    chk(awCount == 2, "R2 no burst during wait", awCount, 2);
    cyc(100);
    chk(singleCount == 3 && lastLen == 0, "R2 three single bursts", singleCount, 3);
    chk(wrPtr == 16'h0218, "R2 pointer after singles", wrPtr, 16'h0218);

    // unaligned pointer forces single beats
    push(20);
    cyc(250);
    chk(singleCount == 23 && fullCount == 2, "R3 unaligned drains as singles", singleCount, 23);
    chk(wrPtr == 16'h02B8 && fifoLevel == 0, "R3 pointer after 20 singles", wrPtr, 16'h02B8);
    chk(dataBad == 0 && fmtBad == 0, "R10 data order and format", dataBad + fmtBad, 0);
    chk(lastBad == 0 && expWord == 55, "R10 last flag and pop count", expWord, 55);

    // limit stop, interrupt crossing, wrap
    segLimit = 16'h0180;
    pulseInit();
    push(32);
    cyc(80);
    chk(wrPtr == 16'h0180 && fullCount == 3, "R5 stopped at limit", wrPtr, 16'h0180);
    cyc(50);
    chk(fullCount == 3 && fifoLevel == 16, "R5 stays stopped", fullCount, 3);
    intrAddr = 16'h01C0;
    intrEnable = 1;
    chk(intrPending == 0, "R6 no pending before crossing", intrPending, 0);
    segLimit = 16'h0100;
    cyc(60);
    chk(wrPtr == 16'h0200, "R5 resumes after limit move", wrPtr, 16'h0200);
    chk(intrPending == 1, "R6 pending after crossing", intrPending, 1);
    @(negedge clk) intrClear = 1;
    @(negedge clk) intrClear = 0;
    chk(intrPending == 0, "R6 cleared", intrPending, 0);
    push(16);
    cyc(60);
    push(16);
    cyc(60);
    chk(wrPtr == 16'h0100 && fullCount == 6, "R4 wrap to segment start", wrPtr, 16'h0100);
    push(16);
    cyc(60);
    chk(fullCount == 6 && wrPtr == 16'h0100, "R5 wrap lands on limit", fullCount, 6);
    segLimit = 16'h02F8;
    cyc(60);
    chk(wrPtr == 16'h0180 && fifoLevel == 0, "R5 limit moved", wrPtr, 16'h0180);
    chk(intrPending == 0, "R6 no set without crossing", intrPending, 0);

    // error response
    slaveResp = 2'b10;
    ak0 = ackCount;
    push(16);
    cyc(60);
    chk(respError == 1 && wrPtr == 16'h0180, "R8 error holds pointer", wrPtr, 16'h0180);
    chk(ackCount == ak0, "R8 no acknowledge", ackCount, ak0);
    fc0 = fullCount;
    push(16);
    cyc(60);
    chk(fullCount == fc0, "R8 blocked while flagged", fullCount, fc0);
    slaveResp = 2'b00;
    pulseErrClear();
    cyc(60);
    chk(respError == 0 && wrPtr == 16'h0200 && fullCount == fc0 + 1, "R8 resumes after clear", wrPtr, 16'h0200);

    // address range errors
    bufSize = 16'h0200;
    ac0 = awCount;
    push(16);
    cyc(30);
    chk(addrError == 1 && awCount == ac0, "R7 out of window not issued", awCount, ac0);
    bufSize = 16'h1000;
    cyc(30);
    chk(awCount == ac0, "R7 blocked until clear", awCount, ac0);
    pulseErrClear();
    cyc(60);
    chk(addrError == 0 && wrPtr == 16'h0280, "R7 resumes after clear", wrPtr, 16'h0280);
    bufSize = 16'h0000;
    sc0 = singleCount;
    push(1);
    cyc(30);
    chk(addrError == 1 && singleCount == sc0, "R7 zero size refused", singleCount, sc0);
    bufSize = 16'h1000;
    pulseErrClear();
    cyc(30);
    chk(singleCount == sc0 + 1 && wrPtr == 16'h0288, "R7 single after clear", wrPtr, 16'h0288);

    // enable dropped mid-burst
    pulseInit();
    throttle = 1;
    ac0 = awCount;
    fc0 = fullCount;
    push(32);
    for (int i = 0; i < 50 && awCount == ac0; i++) @(negedge clk);
    dmaEnable = 0;
    cyc(5);
    throttle = 0;
    cyc(80);
    chk(fullCount == fc0 + 1 && wrPtr == 16'h0180, "R9 burst completes, no new one", wrPtr, 16'h0180);
    chk(fifoLevel == 16, "R9 remaining words untouched", fifoLevel, 16);
    chk(dataBad == 0 && lastBad == 0 && fmtBad == 0, "R10 final data integrity", dataBad + lastBad, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule